// File: doc/BRIEF.md
# Clock Reference-Bit Victim Selector

This block chooses which physical page frame to give up when a new page must be brought in. It keeps one reference bit and one dirty bit per frame. Access events arriving on a small update port mark a frame as used, and a write access also marks it modified. When a replacement is requested, a cursor walks the frames in circular order. It starts just past the frame chosen last time and stops on the first frame that has not been used recently. Every frame the cursor skips loses its reference bit, so a frame that is not touched again becomes a candidate on the next lap.

A per-request option biases the choice toward frames that are both unused and unmodified, so that no write-back is needed. If one full lap turns up no such frame, the search falls back to the plain unused rule. The victim index is returned together with a one-cycle done pulse. The victim's dirty bit is cleared at that moment, because the frame is about to be refilled.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset, req_ready is 1, victim_done is 0 and victim_idx is 0. All reference and dirty bits are 0, and the cursor stands at frame NUM_FRAMES-1, so the first sweep examines frame 0 first.
- R2: An update with upd_valid=1 sets the reference bit of frame upd_idx. When upd_write=1 it also sets that frame's dirty bit.
- R3: In plain mode (prefer_clean=0 at acceptance), the victim is the first frame with a reference bit of 0. The search starts at the frame after the last victim and moves upward, wrapping from NUM_FRAMES-1 to 0.
- R4: Every frame the sweep examines and passes over has its reference bit cleared to 0.
- R5: The sweep examines one frame per clock cycle. victim_done rises m clock edges after the accepting edge, where m is the number of frames examined including the victim. With no concurrent updates, plain mode needs at most NUM_FRAMES+1 cycles.
- R6: In clean-preferring mode (prefer_clean=1 at acceptance), the first NUM_FRAMES frames examined are accepted only if both their reference bit and their dirty bit are 0. After that, the plain rule of R3 applies. Any search ends within 2*NUM_FRAMES+2 busy cycles.
- R7: The cursor keeps the index of the last victim. The next request starts its search at the following frame.
- R8: When a frame is chosen as victim, its dirty bit is cleared.
- R9: An update that targets the frame under examination in the same cycle wins. That frame is treated as referenced, passed over, and keeps its reference bit set.
- R10: req_ready is 0 from the accepting edge until the cycle in which victim_done is 1, and requests seen while it is 0 are ignored. victim_done is high for exactly one cycle, and victim_idx changes only in a cycle where victim_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Access event strobe |
| upd_idx | input | IDX_W (4) | Frame touched by the access |
| upd_write | input | 1 | Access was a write; also sets the dirty bit |
| req_valid | input | 1 | Replacement request |
| prefer_clean | input | 1 | Clean-preferring mode for this request, sampled at acceptance |
| req_ready | output | 1 | Block is idle and accepts a request |
| victim_done | output | 1 | One-cycle pulse: victim_idx holds a new victim |
| victim_idx | output | IDX_W (4) | Index of the chosen frame |

## Verification
A corrupted cursor or bit array shows up as the wrong victim index on the very next request. It also shows up as a done pulse that arrives too early or too late, because the count of examined frames exposes how many reference bits were still set. Bits that were not cleared, or that were cleared wrongly, change the victim of the following lap, so the bench chains requests and compares every victim and latency against an arithmetic prediction. A dirty bit that survives selection changes the clean-mode outcome on the next lap. Lost update priority adds or removes one cycle and shifts the victim by one frame.

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_write,
  input  logic             req_valid,
  input  logic             prefer_clean,
  output logic             req_ready,
  output logic             victim_done,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] ref_q, dirty_q;
  logic [IDX_W-1:0] ptr_q, cur_q, steps_q, idx_q;
  logic busy_q, pass_q, clean_q, done_q;

  logic hit_cur, cur_ref, want_clean, found;
  logic [IDX_W-1:0] cur_nxt, ptr_nxt;

  assign hit_cur    = upd_valid && (upd_idx == cur_q);
  assign cur_ref    = ref_q[cur_q] | hit_cur;
  assign want_clean = clean_q && !pass_q;
  assign found      = busy_q && !cur_ref && !(want_clean && dirty_q[cur_q]);
  assign cur_nxt    = (cur_q == LAST) ? '0 : cur_q + 1'b1;
  assign ptr_nxt    = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  assign req_ready   = !busy_q;
  assign victim_done = done_q;
  assign victim_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (upd_valid && upd_idx == IDX_W'(i)) begin
          ref_q[i] <= 1'b1;
          if (upd_write) dirty_q[i] <= 1'b1;
        end else if (busy_q && cur_q == IDX_W'(i)) begin
          if (found) dirty_q[i] <= 1'b0;
          else       ref_q[i]   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pass_q  <= 1'b0;
      clean_q <= 1'b0;
      done_q  <= 1'b0;
      ptr_q   <= LAST;
      cur_q   <= '0;
      steps_q <= '0;
      idx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q  <= 1'b1;
          cur_q   <= ptr_nxt;
          steps_q <= '0;
          pass_q  <= 1'b0;
          clean_q <= prefer_clean;
        end
      end else if (found) begin
        busy_q <= 1'b0;
        ptr_q  <= cur_q;
        idx_q  <= cur_q;
        done_q <= 1'b1;
      end else begin
        cur_q   <= cur_nxt;
        steps_q <= steps_q + 1'b1;
        if (want_clean && steps_q == LAST) pass_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clock_victim_picker_chk.sv
module clock_victim_picker_chk #(
  parameter int NUM_FRAMES = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             victim_done,
  input logic [IDX_W-1:0] victim_idx
);
  localparam int BOUND = 2 * NUM_FRAMES + 2;
  localparam int CW = $clog2(BOUND + 2);

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || req_ready) busy_cnt <= '0;
    else if (busy_cnt != {CW{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    victim_done |=> !victim_done);

  p_busy_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !victim_done);

  p_idx_only_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(victim_idx) |-> victim_done);

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_sweep_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(BOUND));
endmodule

bind clock_victim_picker clock_victim_picker_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .victim_done(victim_done), .victim_idx(victim_idx));

// File: tb/clock_victim_picker_tb_top.sv
module clock_victim_picker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0, upd_write = 1'b0, req_valid = 1'b0, prefer_clean = 1'b0;
  logic [3:0] upd_idx = '0;
  logic req_ready, victim_done;
  logic [3:0] victim_idx;

  int n_checks = 0;
  int n_fail = 0;

  bit [N-1:0] m_ref, m_dirty;
  int m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_victim_picker #(.NUM_FRAMES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_write(upd_write), .req_valid(req_valid), .prefer_clean(prefer_clean),
    .req_ready(req_ready), .victim_done(victim_done), .victim_idx(victim_idx));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ref = '0; m_dirty = '0; m_ptr = N - 1;
  endtask

  task automatic upd(input int idx, input bit wr);
    upd_valid = 1'b1; upd_idx = 4'(idx); upd_write = wr;
    @(negedge clk);
    upd_valid = 1'b0; upd_write = 1'b0;
    m_ref[idx] = 1'b1;
    if (wr) m_dirty[idx] = 1'b1;
  endtask

  task automatic set_mask(input bit [N-1:0] mask, input bit wr);
    for (int b = 0; b < N; b++) if (mask[b]) upd(b, wr);
  endtask

  function automatic void predict(input bit mode, output int vic, output int steps);
    int cur = m_ptr;
    bit pass1 = 1'b0;
    steps = 0;
    forever begin
      cur = (cur + 1) % N;
      steps++;
      if (!m_ref[cur] && !(mode && !pass1 && m_dirty[cur])) break;
      m_ref[cur] = 1'b0;
      if (mode && !pass1 && steps == N) pass1 = 1'b1;
    end
    vic = cur;
    m_dirty[cur] = 1'b0;
    m_ptr = cur;
  endfunction

  task automatic run_req(input bit mode, input int exp_idx, input int exp_lat,
                         input string tag, input bit hit_first, input bit poke);
    int lat = 0;
    prefer_clean = mode;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit_first) begin upd_valid = 1'b1; upd_idx = 4'((m_ptr + 1) % N); upd_write = 1'b0; end
    while (lat < 100) begin
      @(negedge clk);
      lat++;
      upd_valid = 1'b0;
      req_valid = poke && (lat == 3);
      if (victim_done) break;
      chk(!req_ready, {tag, " R10 ready low while busy"}, req_ready, 0);
    end
    req_valid = 1'b0;
    chk(victim_done == 1'b1, {tag, " R5 done seen"}, victim_done, 1);
    chk(victim_idx == 4'(exp_idx), {tag, " victim index"}, victim_idx, exp_idx);
    chk(lat == exp_lat, {tag, " R5 latency"}, lat, exp_lat);
    @(negedge clk);
    chk(victim_done == 1'b0, {tag, " R10 done one cycle"}, victim_done, 0);
    chk(victim_idx == 4'(exp_idx), {tag, " R10 idx held"}, victim_idx, exp_idx);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v, s;
    do_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(victim_done == 1'b0, "R1 done after reset", victim_done, 0);
    chk(victim_idx == 4'd0, "R1 idx after reset", victim_idx, 0);
    run_req(1'b0, 0, 1, "R1 R3 first sweep", 1'b0, 1'b0);

    // R2 R3 R4: refs on 1..5 from cursor 0
    set_mask(16'h003E, 1'b0);
    run_req(1'b0, 6, 6, "R2 R3 skip referenced", 1'b0, 1'b0);
    run_req(1'b0, 7, 1, "R4 R7 refs cleared", 1'b0, 1'b0);
    run_req(1'b0, 8, 1, "R7 next after victim", 1'b0, 1'b0);

    // R6: frames 9,10 dirty (and referenced) then refs cleared by plain sweep
    set_mask(16'h0600, 1'b1);
    run_req(1'b0, 11, 3, "R2 R4 dirty frames referenced", 1'b0, 1'b0);
    set_mask(16'h0000, 1'b0);
    run_req(1'b1, 12, 1, "R6 clean unreferenced", 1'b0, 1'b0);

    // R6 fallback: only dirty frames 9,10 unreferenced, rest referenced
    set_mask(16'hF9FF, 1'b0);
    run_req(1'b1, 13, 17, "R6 fallback after full lap", 1'b0, 1'b0);

    // R5 R8: all referenced, frame 0 dirty, plain worst case
    do_reset();
    upd(0, 1'b1);
    set_mask(16'hFFFE, 1'b0);
    run_req(1'b0, 0, 17, "R5 R8 worst plain lap", 1'b0, 1'b0);
    set_mask(16'hFFFE, 1'b1);
    run_req(1'b1, 0, 16, "R8 dirty cleared on victim", 1'b0, 1'b0);

    // R9: same-cycle set on first examined frame
    do_reset();
    set_mask(16'hFFFE, 1'b0);
    run_req(1'b0, 1, 18, "R9 update beats clear", 1'b1, 1'b0);

    // R10: request during busy ignored
    do_reset();
    set_mask(16'hFFFF, 1'b0);
    run_req(1'b0, 0, 17, "R10 busy request", 1'b0, 1'b1);
    begin
      bit extra = 1'b0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (victim_done || !req_ready) extra = 1'b1;
      end
      chk(!extra, "R10 busy request ignored", extra, 0);
    end

    // Sweep with model: R3 R4 R6 R7 R8
    do_reset();
    for (int it = 0; it < 150; it++) begin
      bit [N-1:0] a, b, rm, dm;
      bit mode;
      a = 16'((it * 40503) ^ (it * 7919 >> 3) ^ 16'h5A3C);
      b = 16'((it * 2654435 >> 4) ^ (it * 97));
      rm = a & (a >> 5) & ~(16'(it) << 2);
      dm = a & b & (b >> 7);
      mode = it[0] ^ it[2];
      for (int k = 0; k < N; k++) begin
        if (dm[k]) upd(k, 1'b1);
        else if (rm[k]) upd(k, 1'b0);
      end
      predict(mode, v, s);
      run_req(mode, v, s, mode ? "R6 R4 R8 sweep clean" : "R3 R4 R7 sweep plain", 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule